// File: doc/BRIEF.md
# Pin-Driven Reference Pair Selector

This block is used by the reference selector of a timing loop. It lets a board-level select pin choose the loop's reference instead of the automatic priority logic. The pin does not name an input directly. It chooses between two pairs of candidate clock inputs. A high level picks the pair made of input 3 and input 5. A low level picks the pair made of input 4 and input 6. Within the chosen pair, the first member is forced while its priority setting is nonzero. A zero priority on that first member hands the force to its partner. The block has no reference-validity input, so the forced index is held even when the chosen clock is dead.

The override mode has an enable bit. Its default is not a constant: while reset is held, the block copies the pin level into the enable bit. The same captured level also sets a one-bit default for the frequency-tolerance limit. Code 1 means the wide ±80 ppm window and code 0 means the usual ±9.2 ppm window. After reset, a single write strobe can replace both bits. The result is a forced-input index, where 0 means "no override" and automatic selection stays in charge, together with the tolerance code. Switching of the clock signals themselves happens elsewhere.

Top module: `ext_ref_switch`

## Requirements
- R1: With override enabled and the synchronized pin high, `force_idx` is 3 when `prio_hi_main` is nonzero.
- R2: With override enabled and the synchronized pin high, `force_idx` is 5 when `prio_hi_main` is zero.
- R3: With override enabled and the synchronized pin low, `force_idx` is 4 when `prio_lo_main` is nonzero.
- R4: With override enabled and the synchronized pin low, `force_idx` is 6 when `prio_lo_main` is zero.
- R5: After a reset with no later write, the override enable equals the pin level held during reset: a high pin gives a nonzero `force_idx` and a low pin gives 0.
- R6: After a reset with no later write, `tol_wide` equals the pin level held during reset (1 = ±80 ppm window, 0 = ±9.2 ppm window).
- R7: A change on `sel_pin` reaches `force_idx` at the second rising clock edge after it and not at the first.
- R8: A write (`cfg_we` high at a rising edge, after reset) loads `cfg_mode_en`. While the enable is 0, `force_idx` is 0.
- R9: The same write loads `cfg_tol_wide` into `tol_wide`. Without a write, `tol_wide` keeps its value.
- R10: `force_idx` is 0 while `rst_n` is low and until the second rising edge after `rst_n` rises. Writes made in that window are ignored.
- R11: A change on a priority input shows on `force_idx` in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_pin | input | 1 | Asynchronous external pair-select pin |
| prio_hi_main | input | PRIO_W | Priority setting of input 3 |
| prio_lo_main | input | PRIO_W | Priority setting of input 4 |
| cfg_we | input | 1 | Write strobe for the configuration bits |
| cfg_mode_en | input | 1 | Override enable value to write |
| cfg_tol_wide | input | 1 | Tolerance code value to write |
| force_idx | output | 4 | Forced input index, 0 meaning no override |
| tol_wide | output | 1 | Default tolerance code, 1 for the wide window |

## Verification
A bad enable bit shows at once and keeps showing. From the first cycle after the reset window, `force_idx` is either stuck at 0 or forcing an input, whatever the pin does. A wrongly captured tolerance default differs from the pin level on `tol_wide` on every cycle until the next write. A synchronizer with the wrong depth moves every pin response one edge early or late, so the per-cycle comparison catches it at the first toggle. A wrong fallback rule shows only in the cycles where a main priority is zero, and the bench drives those cycles on purpose.

// File: rtl/ers_pkg.sv
`timescale 1ns/1ps
package ers_pkg;
  localparam int IDX_W = 4;
  localparam logic [IDX_W-1:0] IDX_NONE    = 4'd0;
  localparam logic [IDX_W-1:0] IDX_HI_MAIN = 4'd3;
  localparam logic [IDX_W-1:0] IDX_LO_MAIN = 4'd4;
  localparam logic [IDX_W-1:0] IDX_HI_ALT  = 4'd5;
  localparam logic [IDX_W-1:0] IDX_LO_ALT  = 4'd6;

  typedef struct packed {
    logic mode_en;
    logic tol_wide;
  } ers_cfg_t;
endpackage

// File: rtl/ers_rst_sync.sv
`timescale 1ns/1ps
module ers_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rst_ok = pipe_q[STAGES-1];
endmodule

// File: rtl/ers_bit_sync.sv
`timescale 1ns/1ps
module ers_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  // Not reset: it must carry the pin level while reset is held.
  always_ff @(posedge clk) begin
    sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/ers_cfg.sv
`timescale 1ns/1ps
module ers_cfg import ers_pkg::*; (
  input  logic     clk,
  input  logic     rst_ok,
  input  logic     pin_s,
  input  logic     wr_en,
  input  ers_cfg_t wr_data,
  output ers_cfg_t cfg_q
);
  ers_cfg_t cfg_d;
  logic     load;

  always_comb begin
    load  = !rst_ok || wr_en;
    cfg_d = cfg_q;
    if (!rst_ok) begin
      cfg_d.mode_en  = pin_s;
      cfg_d.tol_wide = pin_s;
    end else if (wr_en) begin
      cfg_d = wr_data;
    end
  end

  // The default is the pin level, so loading happens on the clock.
  always_ff @(posedge clk) begin
    if (load) cfg_q <= cfg_d;
  end
endmodule

// File: rtl/ers_pick.sv
`timescale 1ns/1ps
module ers_pick import ers_pkg::*; #(
  parameter int PRIO_W = 4
) (
  input  logic              active,
  input  logic              mode_en,
  input  logic              pin_s,
  input  logic [PRIO_W-1:0] prio_hi_main,
  input  logic [PRIO_W-1:0] prio_lo_main,
  output logic [IDX_W-1:0]  force_idx
);
  logic [IDX_W-1:0] hi_pick;
  logic [IDX_W-1:0] lo_pick;

  always_comb begin
    hi_pick = (prio_hi_main != '0) ? IDX_HI_MAIN : IDX_HI_ALT;
    lo_pick = (prio_lo_main != '0) ? IDX_LO_MAIN : IDX_LO_ALT;
    if (active && mode_en) force_idx = pin_s ? hi_pick : lo_pick;
    else                   force_idx = IDX_NONE;
  end
endmodule

// File: rtl/ext_ref_switch.sv
`timescale 1ns/1ps
module ext_ref_switch import ers_pkg::*; #(
  parameter int PRIO_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_pin,
  input  logic [PRIO_W-1:0] prio_hi_main,
  input  logic [PRIO_W-1:0] prio_lo_main,
  input  logic              cfg_we,
  input  logic              cfg_mode_en,
  input  logic              cfg_tol_wide,
  output logic [IDX_W-1:0]  force_idx,
  output logic              tol_wide
);
  logic     rst_ok;
  logic     pin_s;
  logic     mode_en;
  ers_cfg_t wr_data;
  ers_cfg_t cfg_q;

  ers_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ok(rst_ok)
  );

  ers_bit_sync #(.STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .d(sel_pin), .q(pin_s)
  );

  always_comb begin
    wr_data.mode_en  = cfg_mode_en;
    wr_data.tol_wide = cfg_tol_wide;
  end

  ers_cfg u_cfg (
    .clk(clk), .rst_ok(rst_ok), .pin_s(pin_s),
    .wr_en(cfg_we), .wr_data(wr_data), .cfg_q(cfg_q)
  );

  assign mode_en  = cfg_q.mode_en;
  assign tol_wide = cfg_q.tol_wide;

  ers_pick #(.PRIO_W(PRIO_W)) u_pick (
    .active(rst_ok), .mode_en(mode_en), .pin_s(pin_s),
    .prio_hi_main(prio_hi_main), .prio_lo_main(prio_lo_main),
    .force_idx(force_idx)
  );
endmodule

// File: rtl/ers_chk.sv
`timescale 1ns/1ps
module ers_chk #(
  parameter int PRIO_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_pin,
  input logic [PRIO_W-1:0] prio_hi_main,
  input logic [PRIO_W-1:0] prio_lo_main,
  input logic              cfg_we,
  input logic              cfg_mode_en,
  input logic              cfg_tol_wide,
  input logic [3:0]        force_idx,
  input logic              tol_wide,
  input logic              rst_ok,
  input logic              pin_s,
  input logic              mode_en
);
  AST_HI_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && mode_en && pin_s && prio_hi_main != '0) |-> force_idx == 4'd3); // R1
  AST_HI_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && mode_en && pin_s && prio_hi_main == '0) |-> force_idx == 4'd5); // R2
  AST_LO_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && mode_en && !pin_s && prio_lo_main != '0) |-> force_idx == 4'd4); // R3
  AST_LO_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && mode_en && !pin_s && prio_lo_main == '0) |-> force_idx == 4'd6); // R4
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && !mode_en) |-> force_idx == 4'd0); // R8
  AST_WRITE_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && cfg_we) |=> mode_en == $past(cfg_mode_en)); // R8
  AST_WRITE_TOL: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && cfg_we) |=> tol_wide == $past(cfg_tol_wide)); // R9
  AST_TOL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && !cfg_we) |=> $stable(tol_wide)); // R9
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_ok |-> force_idx == 4'd0); // R10

  generate
    if (SYNC_STAGES == 2) begin : g_two
      AST_PIN_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_ok |-> pin_s == $past(sel_pin, 2)); // R7
    end
  endgenerate
endmodule

bind ext_ref_switch ers_chk #(.PRIO_W(PRIO_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_pin(sel_pin),
  .prio_hi_main(prio_hi_main), .prio_lo_main(prio_lo_main),
  .cfg_we(cfg_we), .cfg_mode_en(cfg_mode_en), .cfg_tol_wide(cfg_tol_wide),
  .force_idx(force_idx), .tol_wide(tol_wide),
  .rst_ok(rst_ok), .pin_s(pin_s), .mode_en(mode_en)
);

// File: tb/tb_ext_ref_switch.sv
`timescale 1ns/1ps
module tb_ext_ref_switch;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sel_pin;
  logic [3:0] prio_hi_main;
  logic [3:0] prio_lo_main;
  logic       cfg_we;
  logic       cfg_mode_en;
  logic       cfg_tol_wide;
  logic [3:0] force_idx;
  logic       tol_wide;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // behavioural reference state
  int m_p1 = 0, m_p2 = 0, m_rel = 0, m_en = 0, m_tol = 0;

  always #5 clk = ~clk;

  ext_ref_switch dut (
    .clk(clk), .rst_n(rst_n), .sel_pin(sel_pin),
    .prio_hi_main(prio_hi_main), .prio_lo_main(prio_lo_main),
    .cfg_we(cfg_we), .cfg_mode_en(cfg_mode_en), .cfg_tol_wide(cfg_tol_wide),
    .force_idx(force_idx), .tol_wide(tol_wide)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge rst_n) m_rel = 0;

  always @(posedge clk) begin
    if (m_rel < 2) begin
      m_en  = m_p2;
      m_tol = m_p2;
    end else if (cfg_we) begin
      m_en  = int'(cfg_mode_en);
      m_tol = int'(cfg_tol_wide);
    end
    m_p2 = m_p1;
    m_p1 = int'(sel_pin);
    if (rst_n && m_rel < 2) m_rel++;
  end

  // compare every cycle, 2 ns after the inputs change at the falling edge
  always begin
    @(negedge clk);
    #2;
    if (!rst_n || m_rel < 2) chk("R10", int'(force_idx), 0);
    else begin
      if (m_en == 0)        chk("R8", int'(force_idx), 0);
      else if (m_p2 != 0) begin
        if (prio_hi_main != 0) chk("R1", int'(force_idx), 3);
        else                   chk("R2", int'(force_idx), 5);
      end else begin
        if (prio_lo_main != 0) chk("R3", int'(force_idx), 4);
        else                   chk("R4", int'(force_idx), 6);
      end
      chk("R9", int'(tol_wide), m_tol);
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic look();
    #3;
  endtask

  task automatic do_reset(bit pin);
    step();
    rst_n = 1'b0;
    sel_pin = pin;
    repeat (6) step();
    rst_n = 1'b1;
    repeat (3) step();
  endtask

  task automatic wr(bit en, bit tol);
    cfg_we = 1'b1; cfg_mode_en = en; cfg_tol_wide = tol;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sel_pin = 1'b1;
    prio_hi_main = 4'd5; prio_lo_main = 4'd2;
    cfg_we = 1'b0; cfg_mode_en = 1'b0; cfg_tol_wide = 1'b0;
    repeat (6) step();
    chk("R10", int'(force_idx), 0);
    // writes during the reset window are ignored
    rst_n = 1'b1;
    cfg_we = 1'b1; cfg_mode_en = 1'b0; cfg_tol_wide = 1'b0;
    step();
    cfg_we = 1'b0;
    repeat (2) step();
    look();
    chk("R5", int'(force_idx), 3);
    chk("R6", int'(tol_wide), 1);
    step();
    prio_hi_main = 4'd0; look();
    chk("R11", int'(force_idx), 5);
    step();
    sel_pin = 1'b0;
    step(); look();
    chk("R7", int'(force_idx), 5);
    step(); look();
    chk("R7", int'(force_idx), 4);
    step();
    prio_lo_main = 4'd0; look();
    chk("R4", int'(force_idx), 6);
    step();
    prio_lo_main = 4'd9;
    wr(1'b0, 1'b0); look();
    chk("R8", int'(force_idx), 0);
    chk("R9", int'(tol_wide), 0);
    step();
    wr(1'b1, 1'b1); look();
    chk("R8", int'(force_idx), 4);
    chk("R9", int'(tol_wide), 1);
    do_reset(1'b0); look();
    chk("R5", int'(force_idx), 0);
    chk("R6", int'(tol_wide), 0);
    step();
    wr(1'b1, 1'b0); look();
    chk("R3", int'(force_idx), 4);
    step();
    sel_pin = 1'b1; prio_hi_main = 4'd1;
    repeat (2) step(); look();
    chk("R1", int'(force_idx), 3);
    for (int i = 0; i < 400; i++) begin
      step();
      sel_pin      = ($urandom_range(0, 3) == 0) ? ~sel_pin : sel_pin;
      prio_hi_main = ($urandom_range(0, 2) == 0) ? 4'd0 : 4'($urandom_range(1, 15));
      prio_lo_main = ($urandom_range(0, 2) == 0) ? 4'd0 : 4'($urandom_range(1, 15));
      cfg_we       = ($urandom_range(0, 9) == 0);
      cfg_mode_en  = ($urandom_range(0, 3) != 0);
      cfg_tol_wide = 1'($urandom_range(0, 1));
    end
    step();
    cfg_we = 1'b0;
    repeat (3) step();
    finish_run();
  end
endmodule